// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt-condition pulses from peripherals and external pins and arbitrates them for a small 8-bit processor core. Each pulse sets a pending flag. The flag is set even when that source is disabled. A request is formed from the flag, a per-source enable, a per-source priority bit and a global enable. The block checks for requests only at instruction boundaries, which the core signals with a one-cycle pulse.

When a request is taken, the block emits a one-cycle vector pulse. The pulse carries the fixed service-routine address of the winning source and the priority level it runs at. The block then marks that level as in service. A return pulse from the core releases the highest level in service. A compile-time mask picks the sources whose flag hardware clears on vectoring. All other flags stay set until software clears them. A small register port, selected by a two-bit code, lets software read and write the flags, the enables, the priority bits and the global enable.

Top module: `irq_ctrl_2lvl`

## Requirements
- R1: After reset, all pending flags, enables, priority bits and the global enable are 0. `vec_req` is 0 and `in_service` is 2'b00.
- R2: A 1 on `src_evt[i]` at a rising edge sets pending flag i at that edge, whatever the enables hold. The flags read back on `reg_rdata` when `reg_sel` is 0.
- R3: If software writes the pending register in the same cycle as an event on source i, flag i ends up 1.
- R4: Source i requests only when its pending flag (reg_sel 0), its enable bit (reg_sel 1) and the global enable (bit 0 at reg_sel 3) are all 1. When the global enable is 0, nothing is vectored.
- R5: `vec_req` is a one-cycle pulse. It is asserted only in the cycle after a cycle where `insn_done` was 1 and a request was eligible. `vec_addr` equals VEC_BASE + index*VEC_STRIDE of the winner.
- R6: Priority bit 1 (reg_sel 2) makes a source high level. A high-level request beats any low-level one. Within a level, the lowest index wins. `vec_lvl` gives the winner's level.
- R7: On vectoring, the winner's flag is cleared only if its bit in HW_CLR is 1. Otherwise the flag stays set.
- R8: A vector sets `in_service[lvl]`. A low-level request is taken only while `in_service` is 2'b00. A high-level request is taken only while `in_service[1]` is 0.
- R9: A `reti` pulse clears the highest set bit of `in_service`.
- R10: No vector is taken in a cycle with `reti`. A flag still pending and enabled after a return is vectored at the next `insn_done` pulse, which marks the end of exactly one further instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Interrupt-condition pulses, one per source |
| insn_done | input | 1 | Instruction boundary pulse from the core |
| reti | input | 1 | Return-from-interrupt completion pulse |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 pending, 1 enable, 2 priority, 3 global enable (bit 0) |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Register read data (combinational) |
| vec_req | output | 1 | Vector request pulse |
| vec_addr | output | VEC_W | Service-routine address of the winner |
| vec_lvl | output | 1 | Level of the vectored source (1 = high) |
| in_service | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
Flag and enable changes appear on `reg_rdata` one edge after the event or write. The bench drives on the falling edge and reads back at the next falling edge. A vector appears one edge after the `insn_done` cycle, so each boundary task checks `vec_req`, `vec_addr`, `vec_lvl` and `in_service` at the next falling edge. It checks again one cycle later to confirm the pulse has ended. Return handling is checked the same way: one cycle after the `reti` pulse for the in-service bits, and at the first boundary afterwards for re-entry.

// File: rtl/irq_ctrl_2lvl.sv
module irq_ctrl_2lvl #(
  parameter int NSRC       = 8,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [NSRC-1:0] HW_CLR = 8'b0000_0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_evt,
  input  logic             insn_done,
  input  logic             reti,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [NSRC-1:0]  reg_wdata,
  output logic [NSRC-1:0]  reg_rdata,
  output logic             vec_req,
  output logic [VEC_W-1:0] vec_addr,
  output logic             vec_lvl,
  output logic [1:0]       in_service
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  pend_q, en_q, prio_q, req, hi_req, lo_req, clr_mask;
  logic             gie_q, hi_any, lo_any, take_hi, take_lo, take;
  logic [IDX_W-1:0] hi_idx, lo_idx, win_idx;

  assign req    = pend_q & en_q & {NSRC{gie_q}};
  assign hi_req = req & prio_q;
  assign lo_req = req & ~prio_q;

  always_comb begin
    hi_any = 1'b0; hi_idx = '0;
    lo_any = 1'b0; lo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hi_req[i]) begin hi_any = 1'b1; hi_idx = IDX_W'(i); end
      if (lo_req[i]) begin lo_any = 1'b1; lo_idx = IDX_W'(i); end
    end
  end

  assign take_hi  = hi_any & ~in_service[1];
  assign take_lo  = lo_any & ~hi_any & (in_service == 2'b00);
  assign take     = insn_done & ~reti & (take_hi | take_lo);
  assign win_idx  = take_hi ? hi_idx : lo_idx;
  assign clr_mask = (take && HW_CLR[win_idx]) ? (NSRC'(1) << win_idx) : '0;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = pend_q;
      2'd1:    reg_rdata = en_q;
      2'd2:    reg_rdata = prio_q;
      default: reg_rdata = {{(NSRC-1){1'b0}}, gie_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      en_q       <= '0;
      prio_q     <= '0;
      gie_q      <= 1'b0;
      vec_req    <= 1'b0;
      vec_addr   <= '0;
      vec_lvl    <= 1'b0;
      in_service <= 2'b00;
    end else begin
      pend_q <= src_evt |
                (((reg_we && reg_sel == 2'd0) ? reg_wdata : pend_q) & ~clr_mask);
      if (reg_we && reg_sel == 2'd1) en_q   <= reg_wdata;
      if (reg_we && reg_sel == 2'd2) prio_q <= reg_wdata;
      if (reg_we && reg_sel == 2'd3) gie_q  <= reg_wdata[0];
      vec_req <= take;
      if (take) begin
        vec_addr <= VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STRIDE);
        vec_lvl  <= take_hi;
        if (take_hi) in_service[1] <= 1'b1;
        else         in_service[0] <= 1'b1;
      end else if (reti) begin
        if (in_service[1]) in_service[1] <= 1'b0;
        else               in_service[0] <= 1'b0;
      end
    end
  end

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & $past(src_evt)) == $past(src_evt));
  // R5
  vec_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(insn_done));
  // R10
  vec_not_on_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> !$past(reti));
  // R4
  gie_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(gie_q));
  // R8
  lo_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !vec_lvl) |-> ($past(in_service) == 2'b00));
  // R8
  hi_no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && vec_lvl) |-> !$past(in_service[1]));
  // R9
  reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && in_service[1]) |=> !in_service[1]);
endmodule

// File: tb/sim_irq_ctrl_2lvl.sv
`timescale 1ns/1ps
module sim_irq_ctrl_2lvl;
  localparam int NSRC = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src_evt = '0, reg_wdata = '0, reg_rdata;
  logic insn_done = 1'b0, reti = 1'b0, reg_we = 1'b0, vec_req, vec_lvl;
  logic [1:0] reg_sel = 2'd0, in_service;
  logic [15:0] vec_addr;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_ctrl_2lvl u0 (.clk(clk), .rst_n(rst_n), .src_evt(src_evt), .insn_done(insn_done),
    .reti(reti), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec_req(vec_req), .vec_addr(vec_addr), .vec_lvl(vec_lvl),
    .in_service(in_service));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(logic [1:0] sel, logic [NSRC-1:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [NSRC-1:0] d);
    reg_sel = sel; #0.5; d = reg_rdata;
  endtask

  task automatic evt(logic [NSRC-1:0] m);
    src_evt = m; @(negedge clk); src_evt = '0;
  endtask

  task automatic boundary(string tag, bit exp_req, int exp_addr, bit exp_lvl);
    insn_done = 1'b1; @(negedge clk); insn_done = 1'b0;
    chk({tag, " vec_req"}, vec_req, exp_req);
    if (exp_req) begin
      chk({tag, " vec_addr"}, vec_addr, exp_addr);
      chk({tag, " vec_lvl"}, vec_lvl, exp_lvl);
      @(negedge clk);
      chk({tag, " pulse ends"}, vec_req, 0);
    end
  endtask

  task automatic do_reti();
    reti = 1'b1; @(negedge clk); reti = 1'b0;
  endtask

  task automatic t_reset();
    logic [NSRC-1:0] d;
    do_reset();
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk("R1 register reset", d, 0);
    end
    chk("R1 vec_req reset", vec_req, 0);
    chk("R1 in_service reset", in_service, 0);
  endtask

  task automatic t_latch_disabled();
    logic [NSRC-1:0] d;
    do_reset();
    wr(2'd3, 8'h01);
    evt(8'h08);
    rd(2'd0, d);
    chk("R2 flag set while disabled", d, 8'h08);
    boundary("R4 disabled source", 0, 0, 0);
    rd(2'd0, d);
    chk("R2 flag kept", d, 8'h08);
  endtask

  task automatic t_event_wins();
    logic [NSRC-1:0] d;
    do_reset();
    src_evt = 8'h10;
    wr(2'd0, 8'h00);
    src_evt = '0;
    rd(2'd0, d);
    chk("R3 event beats software clear", d, 8'h10);
    wr(2'd0, 8'h00);
    rd(2'd0, d);
    chk("R3 software clear alone", d, 8'h00);
  endtask

  task automatic t_basic_and_reentry();
    logic [NSRC-1:0] d;
    do_reset();
    wr(2'd1, 8'h02);
    evt(8'h02);
    boundary("R4 global enable off", 0, 0, 0);
    wr(2'd3, 8'h01);
    @(negedge clk);
    chk("R5 no vector without boundary", vec_req, 0);
    boundary("R5 low vector src1", 1, 11, 0);
    chk("R8 low in service", in_service, 2'b01);
    rd(2'd0, d);
    chk("R7 non-hw-clear flag kept", d, 8'h02);
    reti = 1'b1; insn_done = 1'b1;
    @(negedge clk);
    reti = 1'b0; insn_done = 1'b0;
    chk("R10 no vector in reti cycle", vec_req, 0);
    chk("R9 low released", in_service, 2'b00);
    boundary("R10 re-entry after one instruction", 1, 11, 0);
    do_reti();
  endtask

  task automatic t_priority();
    logic [NSRC-1:0] d;
    do_reset();
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h40);
    wr(2'd3, 8'h01);
    evt(8'h64);
    boundary("R6 high beats low", 1, 51, 1);
    chk("R8 high in service", in_service, 2'b10);
    boundary("R8 low blocked under high", 0, 0, 0);
    do_reti();
    chk("R9 high released", in_service, 2'b00);
    wr(2'd0, 8'h24);
    boundary("R6 lowest index wins", 1, 19, 0);
    rd(2'd0, d);
    chk("R7 hw-clear flag dropped", d, 8'h20);
    boundary("R8 low cannot preempt low", 0, 0, 0);
    evt(8'h40);
    boundary("R8 high preempts low", 1, 51, 1);
    chk("R8 both levels in service", in_service, 2'b11);
    do_reti();
    chk("R9 highest bit popped first", in_service, 2'b01);
    do_reti();
    chk("R9 last level popped", in_service, 2'b00);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latch_disabled();
    t_event_wins();
    t_basic_and_reentry();
    t_priority();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule